// File: doc/BRIEF.md
# Bidirectional Port with Segment-Gated Pull-up

This block is one general-purpose I/O port of configurable width. Software sees three registers: an output latch, a per-pin direction register and a control register. The block turns them into three pin-facing vectors: output enable, output data and pull-up enable. Reads of the data register return a mix. Pins that are driving return the latch bit. Pins that are not driving return the external level, taken through a two-flop synchronizer.

A parameter selects one of two flavours. In the segment flavour, the control register holds one segment-disable bit per pin. That bit gates both driving and pull-up: a pin drives only when both its direction bit and its control bit are 1, and it is pulled up when its direction bit is 0 and its control bit is 1. In the plain flavour, direction alone decides driving. Bit 0 of the control register is then a single pull-up switch shared by all pins, and it only reaches pins whose direction bit is 0. The other control bits are not stored.

Register select on `addr`: 0 = output latch, 1 = direction, 2 = control, 3 = unused. Writes take effect at the clock edge. Reads are combinational from `addr`.

Top module: `gpio_seg_port`

## Requirements
- R1: While `rst` is high at a clock edge, all registers and the synchronizer clear to 0. After that edge `pin_oe`, `pin_out` and `pin_pu` are all 0, and reads at addresses 0, 1 and 2 return 0.
- R2: A pin whose direction bit is 0 has `pin_oe` at 0 in both flavours.
- R3: Segment flavour: `pin_oe[i]` is 1 exactly when direction bit i and control bit i are both 1.
- R4: Plain flavour: `pin_oe[i]` equals direction bit i, and the control register has no effect on it.
- R5: A read at address 0 returns the latch bit for every pin whose `pin_oe` is 1.
- R6: A read at address 0 returns `pin_in[i]` as sampled two clock edges earlier for every pin whose `pin_oe` is 0.
- R7: A write at address 0 updates the latch for all pins, and `pin_out` shows it after the edge. Pins with `pin_oe` at 0 stay undriven.
- R8: Segment flavour: `pin_pu[i]` is 1 exactly when direction bit i is 0 and control bit i is 1.
- R9: Plain flavour: every `pin_pu[i]` equals control bit 0 AND NOT direction bit i. Control bits above 0 are not stored and read back as 0. No pin is ever both driving and pulled up.
- R10: Reads at addresses 1 and 2 return the direction and control registers. A read at address 3 returns 0. A write at address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 latch, 1 direction, 2 control, 3 unused |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Combinational read data for `addr` |
| pin_in | input | WIDTH | External pin levels (asynchronous) |
| pin_oe | output | WIDTH | Per-pin output enable |
| pin_out | output | WIDTH | Per-pin output data (latch) |
| pin_pu | output | WIDTH | Per-pin pull-up enable |

## Verification
The hardest state to reach from the ports is a data-register read where pins are mixed: some drive the latch, some are set to output but gated off by a zero segment bit, and the pin level changed less than two edges ago. A correct block returns the latch on some bits and a stale synchronized level on the others. The stimulus gets there by first writing the direction register with the control register still 0, then toggling `pin_in` on consecutive cycles while holding the data address. A random phase then interleaves register writes with pin changes. Both flavours are instantiated side by side on the same stimulus, so each cycle shows how the control register affects each of them.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PORT_PLAIN   = 1'b0,
        PORT_SEGMENT = 1'b1
    } port_kind_e;

    // Number of control bits that are stored for a flavour
    function automatic int ctrl_bits(port_kind_e kind, int width);
        return (kind == PORT_SEGMENT) ? width : 1;
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_kind_e KIND  = PORT_SEGMENT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] ctrl_q
);
    localparam int               NCTRL     = ctrl_bits(KIND, WIDTH);
    localparam logic [WIDTH-1:0] CTRL_MASK = (NCTRL == WIDTH) ? '1 : WIDTH'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_DATA: data_q <= wr_data;
                REG_DIR:  dir_q  <= wr_data;
                REG_CTRL: ctrl_q <= wr_data & CTRL_MASK;
                default:  ;
            endcase
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (data_q == '0 && dir_q == '0 && ctrl_q == '0));

    p_latch_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_DATA) |=> data_q == $past(wr_data));

    p_unused_write_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_NONE) |=> ($stable(data_q) && $stable(dir_q) && $stable(ctrl_q)));
endmodule

// File: rtl/gpio_port_pad_ctrl.sv
module gpio_port_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_kind_e KIND  = PORT_SEGMENT
) (
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] ctrl_q,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] out,
    output logic [WIDTH-1:0] pu
);
    assign out = data_q;

    generate
        if (KIND == PORT_SEGMENT) begin : g_segment
            assign oe = dir_q & ctrl_q;
            assign pu = ~dir_q & ctrl_q;
        end else begin : g_plain
            // only bit 0 of ctrl_q can be set, so the OR reduction is that bit
            assign oe = dir_q;
            assign pu = ~dir_q & {WIDTH{|ctrl_q}};
        end
    endgenerate
endmodule

// File: rtl/gpio_seg_port.sv
module gpio_seg_port
    import gpio_port_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_kind_e KIND  = PORT_SEGMENT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pu
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] data_q, dir_q, ctrl_q, pin_sync;

    assign sel = reg_sel_e'(addr);

    gpio_port_sync #(.WIDTH(WIDTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_port_regs #(.WIDTH(WIDTH), .KIND(KIND)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .ctrl_q  (ctrl_q)
    );

    gpio_port_pad_ctrl #(.WIDTH(WIDTH), .KIND(KIND)) u_pad (
        .data_q (data_q),
        .dir_q  (dir_q),
        .ctrl_q (ctrl_q),
        .oe     (pin_oe),
        .out    (pin_out),
        .pu     (pin_pu)
    );

    always_comb begin
        case (sel)
            REG_DATA: rd_data = (data_q & pin_oe) | (pin_sync & ~pin_oe);
            REG_DIR:  rd_data = dir_q;
            REG_CTRL: rd_data = ctrl_q;
            default:  rd_data = '0;
        endcase
    end

    // R9: a pin is never both driven and pulled up
    p_drive_pull_excl_r9: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & pin_pu) == '0);

    p_input_read_lag_r6: assert property (@(posedge clk) disable iff (rst)
        (addr == 2'd0 && !$past(rst, 1) && !$past(rst, 2))
            |-> ((rd_data ^ $past(pin_in, 2)) & ~pin_oe) == '0);

    p_input_undriven_r2: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && addr == 2'd1 && !rst) |-> (pin_oe & ~$past(wr_data)) == '0);
endmodule

// File: tb/gpio_seg_port_test.sv
module gpio_seg_port_test;
    import gpio_port_pkg::*;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] pin_in = '0;

    logic [W-1:0] s_rd, s_oe, s_out, s_pu;
    logic [W-1:0] p_rd, p_oe, p_out, p_pu;

    always #2 clk = ~clk;  // 250 MHz

    gpio_seg_port #(.WIDTH(W), .KIND(PORT_SEGMENT)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(s_rd), .pin_in(pin_in), .pin_oe(s_oe), .pin_out(s_out), .pin_pu(s_pu)
    );

    gpio_seg_port #(.WIDTH(W), .KIND(PORT_PLAIN)) uut_plain (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(p_rd), .pin_in(pin_in), .pin_oe(p_oe), .pin_out(p_out), .pin_pu(p_pu)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int unsigned m_latch = 0, m_dir = 0, m_seg = 0, m_pull = 0;
    int unsigned pin_hist[$];   // pin samples, newest at the back

    always @(posedge clk) begin
        if (rst) begin
            m_latch = 0; m_dir = 0; m_seg = 0; m_pull = 0;
            pin_hist = '{0, 0};
        end else begin
            if (wr_en) begin
                if (addr == 0) m_latch = wr_data;
                else if (addr == 1) m_dir = wr_data;
                else if (addr == 2) begin
                    m_seg  = wr_data;
                    m_pull = wr_data % 2;
                end
            end
            pin_hist.push_back(pin_in);
            void'(pin_hist.pop_front());
        end
    end

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_read(int unsigned oe, int unsigned ctl);
        int unsigned v;
        case (addr)
            2'd0: v = (m_latch & oe) | (pin_hist[0] & ~oe);
            2'd1: v = m_dir;
            2'd2: v = ctl;
            default: v = 0;
        endcase
        return W'(v);
    endfunction

    task automatic compare_all();
        int unsigned s_oe_e, p_oe_e, s_pu_e, p_pu_e;
        string rtag;
        s_oe_e = m_dir & m_seg;                        // R3, R2
        s_pu_e = ~m_dir & m_seg;                       // R8
        p_oe_e = m_dir;                                // R4
        p_pu_e = (m_pull != 0) ? ~m_dir : 0;           // R9
        rtag = (addr == 0) ? "R5/R6 data read" : "R10 register read";
        check("R3 segment oe",  s_oe,  W'(s_oe_e));
        check("R4 plain oe",    p_oe,  W'(p_oe_e));
        check("R8 segment pull", s_pu, W'(s_pu_e));
        check("R9 plain pull",  p_pu,  W'(p_pu_e));
        check("R7 segment out", s_out, W'(m_latch));
        check("R7 plain out",   p_out, W'(m_latch));
        check({rtag, " segment"}, s_rd, exp_read(s_oe_e, m_seg));
        check({rtag, " plain"},   p_rd, exp_read(p_oe_e, m_pull));
    endtask

    // compare on every falling edge, while not in reset
    always @(negedge clk) if (!rst && !done) compare_all();

    task automatic step(logic we, logic [1:0] a, logic [W-1:0] d, logic [W-1:0] pins);
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; pin_in = pins;
    endtask

    initial begin
        pin_hist = '{0, 0};
        pin_in = 8'hA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state seen at the ports
        check("R1 oe",  s_oe | p_oe, '0);
        check("R1 pull", s_pu | p_pu, '0);
        check("R1 out", s_out | p_out, '0);

        // R7: latch write while all pins are inputs, nothing driven (R2)
        step(1, 2'd0, 8'h3C, 8'hA5);
        step(0, 2'd0, 8'h00, 8'h5A);
        step(0, 2'd0, 8'h00, 8'hFF);
        // R3/R4: direction set while segment bits still zero
        step(1, 2'd1, 8'hF0, 8'h0F);
        step(0, 2'd0, 8'h00, 8'hF0);   // R6: mixed pins toggling
        step(0, 2'd0, 8'h00, 8'h33);
        step(0, 2'd0, 8'h00, 8'hCC);
        // R8/R9: control register opens segment gates and plain pull-up
        step(1, 2'd2, 8'h99, 8'hCC);
        step(0, 2'd0, 8'h00, 8'h00);   // R5: latch on driving pins
        step(0, 2'd2, 8'h00, 8'h00);   // R9: upper bits dropped in plain
        step(0, 2'd1, 8'h00, 8'h00);
        // R10: write to unused address changes nothing
        step(1, 2'd3, 8'hFF, 8'h00);
        step(0, 2'd3, 8'h00, 8'h00);
        step(0, 2'd2, 8'h00, 8'h00);
        step(1, 2'd2, 8'hFE, 8'h00);   // R9: bit 0 clear means no plain pull
        step(0, 2'd2, 8'h00, 8'h00);

        for (int i = 0; i < 400; i++)
            step(($urandom % 3) == 0, 2'($urandom), 8'($urandom), 8'($urandom));

        // mid-run reset, then R1 again
        @(negedge clk); rst = 1'b1; wr_en = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0; addr = 2'd1;
        @(negedge clk);
        check("R1 dir read", s_rd | p_rd, '0);
        step(0, 2'd0, 8'h00, 8'h00);

        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule